// File: doc/BRIEF.md
# Fractional-Step Serial Clock Generator

This block produces the serial clock of a SPI master from a much faster reference clock. It does not count to a fixed divisor. Each reference cycle it adds a programmable 16-bit step to a small phase accumulator. Every time the accumulator crosses its threshold, the serial clock moves one edge. Because the remainder is normally kept, the average output rate can be any fraction of the reference rate. For a divide ratio D, the step is about 2048/D rounded up.

The transfer engine raises `run` while bits are to be shifted. Edges appear only during that window. When `run` drops, the clock goes back to its idle level and the accumulator empties, so every burst starts from the same phase. Options set by input pins:
- Clock polarity selects the idle level.
- An exact-period option clears the accumulator at each crossing. This trades frequency accuracy for a fixed integer half-period.
- A double-rate option halves the crossing threshold.

The block also gives two single-cycle strobes. The engine uses them to sample receive data on the edge leaving idle and to drive the next bit on the edge returning to idle.

Top module: `sclk_accum_gen`

## Requirements
- R1: During and directly after reset, `sclk` equals `cpol`, both strobes are low, and the accumulator holds zero.
- R2: With `run` high and both options clear, the step is added every reference cycle and an edge occurs whenever the sum reaches 2048, keeping the remainder; over N cycles from a fresh start exactly floor(N*step/2048) edges occur.
- R3: With `wrap_clear` high, the accumulator is emptied at each edge, so edges occur every ceil(threshold/step) cycles.
- R4: With `dbl_rate` high, the threshold is 1024 and the remainder is taken modulo 1024, doubling the edge rate for a given step.
- R5: A step at or above the threshold gives exactly one edge in every cycle, and a step of zero gives no edges.
- R6: `sclk` is `cpol` when the internal phase is idle and its inverse when active; `cpol`=1 gives a clock that idles high.
- R7: `latch_stb` pulses for one cycle in the same cycle that `sclk` leaves its idle level, and `launch_stb` in the cycle it returns; the two alternate, and the first strobe after `run` rises is `latch_stb`.
- R8: In the cycle after a clock edge that sees `run` low, `sclk` equals `cpol`, no strobe is high, and the accumulator is zero, so a new burst times its first edge from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_step | input | 16 | Accumulator step added per reference cycle |
| wrap_clear | input | 1 | Empty the accumulator at each crossing (exact period) |
| dbl_rate | input | 1 | Halve the crossing threshold |
| cpol | input | 1 | Idle level of the serial clock |
| run | input | 1 | Edge enable from the transfer engine |
| sclk | output | 1 | Serial clock |
| latch_stb | output | 1 | Pulse on the edge leaving idle |
| launch_stb | output | 1 | Pulse on the edge returning to idle |

## Verification
Several properties are checked on every cycle:
- The strobes never coincide.
- Each strobe lines up with the matching direction of `sclk`.
- `sclk` never moves without a strobe while running.
- Everything is quiet and idle once `run` has been seen low.

The edge rates can only be shown by the bench's scenarios. These include the fractional counts, the exact-period counts, the halved threshold and the saturation at one edge per cycle. The bench's scenarios also show that the accumulator is emptied between bursts.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;
    parameter int unsigned ACC_W = 11;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             phase;
        logic             latch;
        logic             launch;
    } sclk_state_t;
endpackage

// File: rtl/sclk_accum_step.sv
module sclk_accum_step #(
    parameter int unsigned FREQ_W = 16,
    parameter int unsigned ACC_W  = 11
) (
    input  logic [ACC_W-1:0]  acc_q,
    input  logic [FREQ_W-1:0] step,
    input  logic              dbl_rate,
    input  logic              wrap_clear,
    output logic [ACC_W-1:0]  acc_d,
    output logic              tick
);
    localparam int unsigned SUM_W = ((FREQ_W > ACC_W) ? FREQ_W : ACC_W) + 1;
    localparam logic [SUM_W-1:0] THR_FULL = SUM_W'(1) << ACC_W;
    localparam logic [SUM_W-1:0] THR_HALF = SUM_W'(1) << (ACC_W - 1);

    logic [SUM_W-1:0] sum;
    logic [ACC_W-1:0] rem;

    always_comb begin
        sum = SUM_W'(acc_q) + SUM_W'(step);
        if (dbl_rate) begin
            tick = (sum >= THR_HALF);
            rem  = {1'b0, sum[ACC_W-2:0]};
        end else begin
            tick = (sum >= THR_FULL);
            rem  = sum[ACC_W-1:0];
        end
        acc_d = (tick && wrap_clear) ? '0 : rem;
    end
endmodule

// File: rtl/sclk_edge_shaper.sv
module sclk_edge_shaper (
    input  logic run,
    input  logic tick,
    input  logic phase_q,
    output logic phase_d,
    output logic latch_d,
    output logic launch_d
);
    always_comb begin
        phase_d  = 1'b0;
        latch_d  = 1'b0;
        launch_d = 1'b0;
        if (run) begin
            phase_d = phase_q ^ tick;
            latch_d = tick & ~phase_q;
            launch_d = tick & phase_q;
        end
    end
endmodule

// File: rtl/sclk_accum_gen.sv
module sclk_accum_gen
    import sclk_gen_pkg::*;
#(
    parameter int unsigned FREQ_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREQ_W-1:0] freq_step,
    input  logic              wrap_clear,
    input  logic              dbl_rate,
    input  logic              cpol,
    input  logic              run,
    output logic              sclk,
    output logic              latch_stb,
    output logic              launch_stb
);
    sclk_state_t st_q, st_d;

    logic [ACC_W-1:0] acc_step_d;
    logic             tick;
    logic             phase_d, latch_d, launch_d;

    sclk_accum_step #(.FREQ_W(FREQ_W), .ACC_W(ACC_W)) u_step (
        .acc_q      (st_q.acc),
        .step       (freq_step),
        .dbl_rate   (dbl_rate),
        .wrap_clear (wrap_clear),
        .acc_d      (acc_step_d),
        .tick       (tick)
    );

    sclk_edge_shaper u_shape (
        .run      (run),
        .tick     (tick),
        .phase_q  (st_q.phase),
        .phase_d  (phase_d),
        .latch_d  (latch_d),
        .launch_d (launch_d)
    );

    always_comb begin
        st_d        = st_q;
        st_d.acc    = run ? acc_step_d : '0;
        st_d.phase  = phase_d;
        st_d.latch  = latch_d;
        st_d.launch = launch_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sclk       = cpol ^ st_q.phase;
    assign latch_stb  = st_q.latch;
    assign launch_stb = st_q.launch;
endmodule

// File: rtl/sclk_gen_checker.sv
module sclk_gen_checker (
    input logic clk,
    input logic rst_n,
    input logic cpol,
    input logic run,
    input logic sclk,
    input logic latch_stb,
    input logic launch_stb
);
    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(latch_stb && launch_stb)); // R7
    AST_LATCH_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |-> (sclk != cpol)); // R7
    AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        launch_stb |-> (sclk == cpol)); // R7
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> ((sclk == cpol) && !latch_stb && !launch_stb)); // R8
    AST_NO_SILENT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && run && !latch_stb && !launch_stb && $stable(cpol)) |-> $stable(sclk)); // R6
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |-> (!latch_stb && !launch_stb && (sclk == cpol))); // R1
endmodule

bind sclk_accum_gen sclk_gen_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpol       (cpol),
    .run        (run),
    .sclk       (sclk),
    .latch_stb  (latch_stb),
    .launch_stb (launch_stb)
);

// File: tb/sclk_accum_gen_bench.sv
module sclk_accum_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] freq_step = '0;
    logic        wrap_clear = 1'b0;
    logic        dbl_rate = 1'b0;
    logic        cpol = 1'b0;
    logic        run = 1'b0;
    logic        sclk, latch_stb, launch_stb;
    int          tests = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    sclk_accum_gen u_sclk_accum_gen (
        .clk(clk), .rst_n(rst_n), .freq_step(freq_step), .wrap_clear(wrap_clear),
        .dbl_rate(dbl_rate), .cpol(cpol), .run(run), .sclk(sclk),
        .latch_stb(latch_stb), .launch_stb(launch_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs a burst of n cycles, counts edges, checks strobe/sclk alignment, then stops.
    task automatic burst(input string req, input logic [15:0] f, input logic clr,
                         input logic dbl, input logic cp, input int n, input int exp_edges);
        int edges = 0;
        int bad = 0;
        logic expect_latch = 1'b1;
        @(negedge clk);
        freq_step = f; wrap_clear = clr; dbl_rate = dbl; cpol = cp; run = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (latch_stb || launch_stb) begin
                edges++;
                if (latch_stb != expect_latch) bad++;          // R7 alternation
                if (latch_stb && sclk == cp) bad++;            // R7 / R6 level
                if (launch_stb && sclk != cp) bad++;
                if (latch_stb && launch_stb) bad++;
                expect_latch = ~expect_latch;
            end
        end
        run = 1'b0;
        chk(req, edges, exp_edges);
        chk("R7", bad, 0);
        @(negedge clk);
        chk("R8", int'(sclk == cp && !latch_stb && !launch_stb), 1);
    endtask

    task automatic t_reset();
        cpol = 1'b1;
        #1;
        chk("R1", int'(sclk), 1);
        chk("R1", int'(latch_stb | launch_stb), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(sclk), 1);
    endtask

    task automatic t_idle();
        int seen = 0;
        @(negedge clk);
        freq_step = 16'd2048; run = 1'b0; cpol = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (latch_stb || launch_stb || sclk != cpol) seen++;
        end
        chk("R8", seen, 0);
        cpol = 1'b1; #1;
        chk("R6", int'(sclk), 1);
    endtask

    task automatic t_restart();
        int s1, s2;
        @(negedge clk);
        freq_step = 16'd1500; wrap_clear = 1'b0; dbl_rate = 1'b0; cpol = 1'b0; run = 1'b1;
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        s1 = int'(latch_stb | launch_stb);
        @(negedge clk);
        s2 = int'(latch_stb);
        run = 1'b0;
        chk("R8", s1, 0);
        chk("R8", s2, 1);
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_idle();
        burst("R2", 16'd600,  1'b0, 1'b0, 1'b0, 200, 58);
        burst("R2", 16'd1500, 1'b0, 1'b0, 1'b0, 200, 146);
        burst("R6", 16'd512,  1'b0, 1'b0, 1'b1, 200, 50);
        burst("R3", 16'd600,  1'b1, 1'b0, 1'b0, 200, 50);
        burst("R4", 16'd600,  1'b0, 1'b1, 1'b0, 200, 117);
        burst("R4", 16'd600,  1'b1, 1'b1, 1'b1, 200, 100);
        burst("R5", 16'd2048, 1'b0, 1'b0, 1'b0, 200, 200);
        burst("R5", 16'd4000, 1'b0, 1'b1, 1'b0, 200, 200);
        burst("R5", 16'd0,    1'b0, 1'b0, 1'b0, 200, 0);
        t_restart();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule